// File: doc/BRIEF.md
# Elastic-Latency Tree Multiplier

This block multiplies two unsigned operands (16 bits each by default) and returns the full-width product through a registered output. The partial products go through a tree of 3:2 compressor rows that reduces them to two carry-save vectors. A final merge adder then adds those two vectors. The merge adder is a carry-select design split into two equal halves. Inside each half the select stages widen from 2 bits upward.

The merge adder has a worst-case path: a carry that ripples across the boundary between the two halves. A predictor looks for that case before the adder settles. It inspects a window of bit positions (five by default, so ten bits in total) of the two vectors entering the merge adder. If the two vectors differ at every position in the window, a carry could travel the full chain, and the operation is marked long. A long operation holds the operand and product registers for one extra cycle and writes the product two edges after capture. Every other operation writes its product on the first edge. In this way most products complete in one cycle, and only the rare long-propagation case pays a second cycle.

Upstream logic offers operands with a valid/ready pair. Downstream logic sees a one-cycle strobe each time the product register is loaded.

Top module: `elastic_mult`

## Requirements
- R1: While reset is asserted and directly after its release, `out_valid_o` is 0, `in_ready_o` is 1 and `prod_o` is 0.
- R2: Every product written equals the full 32-bit unsigned product of the captured operands.
- R3: When an operation is short, the product and the strobe appear on the first clock edge after the edge that captured the operands.
- R4: An operation is long when the two merge-adder input vectors differ in every bit from position 14 to 18 (both ends included). The vectors are built by reducing the partial products in levels. At each level the current vectors are taken in groups of three, in index order. Each group gives a sum vector and then a carry vector shifted left by one, and any leftover vectors follow unchanged. A long operation writes its product on the second edge after capture.
- R5: `in_ready_o` is low for exactly one cycle: the cycle in which a long operation is detected. Operands offered in that cycle are not taken, and the captured operands stay unchanged.
- R6: `out_valid_o` pulses once per accepted operation, and only when the product register is loaded.
- R7: After a short operation, a new operand pair is accepted on the same edge that writes the product. Back-to-back short operations therefore run at one per cycle.
- R8: While no operation is in flight, `prod_o` keeps its last value and `out_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair offered |
| in_ready_o | output | 1 | Operand pair can be taken this cycle |
| a_i | input | 16 | Multiplicand |
| b_i | input | 16 | Multiplier |
| out_valid_o | output | 1 | One-cycle strobe when a product is written |
| prod_o | output | 32 | Registered product |

## Verification
The cycle-level rules of the stretch hold on every clock and are covered by assertions. Ready stays low for one cycle only, and a write always follows it. The operands are frozen while ready is low. A strobe appears only after a write enable. The product holds its value between strobes. Other properties need the bench's scenarios to show them. These are the correctness of each product, whether a given operand pair is classified long or short, and the match between the number of stretched operations and an independent evaluation of the window rule. The bench also checks the throughput of back-to-back short operations and behaviour at the operand extremes.

// File: rtl/elastic_mult_pkg.sv
package elastic_mult_pkg;

  // vectors remaining after l reduction levels of 3:2 rows
  function automatic int lvl_cnt(int n, int l);
    int c;
    c = n;
    for (int i = 0; i < l; i++) c = 2 * (c / 3) + c % 3;
    return c;
  endfunction

  function automatic int num_lvls(int n);
    int c, l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = 2 * (c / 3) + c % 3;
      l++;
    end
    return l;
  endfunction

  // select stage widths inside a half: 2, 2, 3, 4, 5, ... clipped at the end
  function automatic int raw_w(int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  function automatic int stg_cnt(int hw);
    int off, k;
    off = 0;
    k = 0;
    while (off < hw) begin
      off += raw_w(k);
      k++;
    end
    return k;
  endfunction

  function automatic int stg_off(int hw, int k);
    int off;
    off = 0;
    for (int i = 0; i < k; i++) off += raw_w(i);
    return (off > hw) ? hw : off;
  endfunction

  function automatic int stg_w(int hw, int k);
    int rem;
    rem = hw - stg_off(hw, k);
    return (raw_w(k) < rem) ? raw_w(k) : rem;
  endfunction

endpackage

// File: rtl/em_cells.sv
module em_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

module em_ha (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i;
  assign co_o = a_i & b_i;
endmodule

// File: rtl/em_csa_row.sv
// One 3:2 compressor row over a whole vector; the carry is shifted left and the top carry dropped.
module em_csa_row #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  assign cry_o[0] = 1'b0;
  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    em_fa u_fa (
      .a_i (x_i[i]),
      .b_i (y_i[i]),
      .c_i (z_i[i]),
      .s_o (sum_o[i]),
      .co_o(cry_o[i+1])
    );
  end
  assign sum_o[W-1] = x_i[W-1] ^ y_i[W-1] ^ z_i[W-1];
endmodule

// File: rtl/em_wallace.sv
module em_wallace
  import elastic_mult_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] vec0_o,
  output logic [2*N-1:0] vec1_o
);
  localparam int W      = 2 * N;
  localparam int LEVELS = num_lvls(N);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
    localparam int C = lvl_cnt(N, l);
    logic [W-1:0] v[C];
    if (l == 0) begin : g_pp
      for (genvar j = 0; j < N; j++) begin : g_row
        assign v[j] = b_i[j] ? ({{N{1'b0}}, a_i} << j) : '0;
      end
    end else begin : g_red
      localparam int P = lvl_cnt(N, l - 1);
      localparam int G = P / 3;
      for (genvar g = 0; g < G; g++) begin : g_grp
        em_csa_row #(.W(W)) u_row (
          .x_i  (g_lv[l-1].v[3*g]),
          .y_i  (g_lv[l-1].v[3*g+1]),
          .z_i  (g_lv[l-1].v[3*g+2]),
          .sum_o(v[2*g]),
          .cry_o(v[2*g+1])
        );
      end
      for (genvar r = 0; r < P % 3; r++) begin : g_pass
        assign v[2*G+r] = g_lv[l-1].v[3*G+r];
      end
    end
  end

  assign vec0_o = g_lv[LEVELS].v[0];
  assign vec1_o = g_lv[LEVELS].v[1];
endmodule

// File: rtl/em_csel_half.sv
// Ripple block; bit 0 is a half adder when the assumed carry-in is 0.
module em_rca #(
  parameter int RW     = 4,
  parameter bit CIN_HI = 1'b0
) (
  input  logic [RW-1:0] a_i,
  input  logic [RW-1:0] b_i,
  output logic [RW-1:0] s_o,
  output logic          co_o
);
  logic [RW:1] cy;
  if (CIN_HI) begin : g_b0_fa
    em_fa u_b0 (.a_i(a_i[0]), .b_i(b_i[0]), .c_i(1'b1), .s_o(s_o[0]), .co_o(cy[1]));
  end else begin : g_b0_ha
    em_ha u_b0 (.a_i(a_i[0]), .b_i(b_i[0]), .s_o(s_o[0]), .co_o(cy[1]));
  end
  for (genvar i = 1; i < RW; i++) begin : g_bit
    em_fa u_fa (.a_i(a_i[i]), .b_i(b_i[i]), .c_i(cy[i]), .s_o(s_o[i]), .co_o(cy[i+1]));
  end
  assign co_o = cy[RW];
endmodule

module em_csel_half
  import elastic_mult_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic [HW-1:0] a_i,
  input  logic [HW-1:0] b_i,
  input  logic          cin_i,
  output logic [HW-1:0] sum_o,
  output logic          cout_o
);
  localparam int NS = stg_cnt(HW);
  logic [NS:0] c;
  assign c[0] = cin_i;

  for (genvar k = 0; k < NS; k++) begin : g_stg
    localparam int OFF = stg_off(HW, k);
    localparam int SW  = stg_w(HW, k);
    logic [SW-1:0] s0, s1;
    logic          co0, co1;
    em_rca #(.RW(SW), .CIN_HI(1'b0)) u_lo (
      .a_i(a_i[OFF+:SW]), .b_i(b_i[OFF+:SW]), .s_o(s0), .co_o(co0));
    em_rca #(.RW(SW), .CIN_HI(1'b1)) u_hi (
      .a_i(a_i[OFF+:SW]), .b_i(b_i[OFF+:SW]), .s_o(s1), .co_o(co1));
    assign sum_o[OFF+:SW] = c[k] ? s1 : s0;
    assign c[k+1]         = c[k] ? co1 : co0;
  end
  assign cout_o = c[NS];
endmodule

// File: rtl/em_predictor.sv
// Flags a long operation when every window position propagates; one state bit marks the stretch cycle.
module em_predictor #(
  parameter int W      = 32,
  parameter int WIN_LO = 14,
  parameter int WIN_W  = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         op_i,
  input  logic [W-1:0] vec0_i,
  input  logic [W-1:0] vec1_i,
  output logic         wr_en_o,
  output logic         hold_o
);
  logic [WIN_W-1:0] prop;
  logic             long_op;
  logic             stretch_q;

  assign prop    = vec0_i[WIN_LO+:WIN_W] ^ vec1_i[WIN_LO+:WIN_W];
  assign long_op = &prop;
  assign hold_o  = op_i & ~stretch_q & long_op;
  assign wr_en_o = op_i & (stretch_q | ~long_op);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stretch_q <= 1'b0;
    else         stretch_q <= hold_o;
  end
endmodule

// File: rtl/elastic_mult.sv
module elastic_mult #(
  parameter int N      = 16,
  parameter int WIN_LO = 14,
  parameter int WIN_W  = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           out_valid_o,
  output logic [2*N-1:0] prod_o
);
  localparam int W  = 2 * N;
  localparam int HW = W / 2;

  logic [N-1:0]  a_q, b_q;
  logic          op_q;
  logic [W-1:0]  prod_q;
  logic          out_valid_q;
  logic [W-1:0]  vec0, vec1, vma_sum;
  logic          mid_c, unused_vma_co;
  logic          wr_en, hold, cap;

  em_wallace #(.N(N)) u_tree (
    .a_i(a_q), .b_i(b_q), .vec0_o(vec0), .vec1_o(vec1));

  em_csel_half #(.HW(HW)) u_vma_lo (
    .a_i(vec0[HW-1:0]), .b_i(vec1[HW-1:0]), .cin_i(1'b0),
    .sum_o(vma_sum[HW-1:0]), .cout_o(mid_c));
  em_csel_half #(.HW(W - HW)) u_vma_hi (
    .a_i(vec0[W-1:HW]), .b_i(vec1[W-1:HW]), .cin_i(mid_c),
    .sum_o(vma_sum[W-1:HW]), .cout_o(unused_vma_co));

  em_predictor #(.W(W), .WIN_LO(WIN_LO), .WIN_W(WIN_W)) u_pred (
    .clk_i, .rst_ni, .op_i(op_q), .vec0_i(vec0), .vec1_i(vec1),
    .wr_en_o(wr_en), .hold_o(hold));

  assign in_ready_o = ~hold;
  assign cap        = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q         <= '0;
      b_q         <= '0;
      op_q        <= 1'b0;
      prod_q      <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= wr_en;
      op_q        <= cap | (op_q & ~wr_en);
      if (wr_en) prod_q <= vma_sum;
      if (cap) begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign prod_o      = prod_q;
endmodule

// File: rtl/elastic_mult_chk.sv
module elastic_mult_chk #(
  parameter int N = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_ready_o,
  input logic           out_valid_o,
  input logic [2*N-1:0] prod_o,
  input logic           wr_en,
  input logic           hold,
  input logic [N-1:0]   a_q,
  input logic [N-1:0]   b_q
);
  AST_WRITE_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> out_valid_o); // R3
  AST_STROBE_HAS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(wr_en)); // R6
  AST_STRETCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> in_ready_o); // R5
  AST_STRETCH_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> wr_en); // R4
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> !wr_en); // R4
  AST_OPERANDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> ($stable(a_q) && $stable(b_q))); // R5
  AST_PROD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(prod_o)); // R8
endmodule

bind elastic_mult elastic_mult_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .prod_o     (prod_o),
  .wr_en      (wr_en),
  .hold       (hold),
  .a_q        (a_q),
  .b_q        (b_q)
);

// File: tb/elastic_mult_test.sv
`timescale 1ns/1ps
module elastic_mult_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] a_i = '0, b_i = '0;
  logic        out_valid_o;
  logic [31:0] prod_o;

  int errors = 0, checks = 0, cyc = 0;
  int n_acc = 0, n_out = 0, model_long_cnt = 0, seen_long_cnt = 0;
  int prev_acc_cyc = -10;
  bit last_long = 1'b0;
  logic [31:0] last_prod = '0;

  logic [31:0] q_prod[$];
  int          q_cap[$];
  bit          q_long[$];

  elastic_mult uut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 reference: level-by-level 3:2 reduction, window 14..18
  function automatic bit model_long(logic [15:0] a, logic [15:0] b);
    logic [31:0] v[16];
    logic [31:0] nv[16];
    logic [31:0] p;
    int n, g, m;
    for (int j = 0; j < 16; j++) v[j] = b[j] ? ({16'h0, a} << j) : 32'h0;
    n = 16;
    while (n > 2) begin
      g = n / 3;
      m = 0;
      for (int i = 0; i < 16; i++) nv[i] = '0;
      for (int i = 0; i < g; i++) begin
        nv[m]   = v[3*i] ^ v[3*i+1] ^ v[3*i+2];
        nv[m+1] = ((v[3*i] & v[3*i+1]) | (v[3*i] & v[3*i+2]) | (v[3*i+1] & v[3*i+2])) << 1;
        m += 2;
      end
      for (int r = 0; r < n % 3; r++) begin
        nv[m] = v[3*g+r];
        m++;
      end
      n = m;
      for (int i = 0; i < 16; i++) v[i] = nv[i];
    end
    p = v[0] ^ v[1];
    return &p[18:14];
  endfunction

  // driver: offer at negedge, retry while not ready
  task automatic issue(logic [15:0] a, logic [15:0] b);
    bit done = 1'b0;
    bit exp_rdy;
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    in_valid_i = 1'b1;
    while (!done) begin
      #1;
      exp_rdy = (prev_acc_cyc == cyc) ? !last_long : 1'b1;
      chk(in_ready_o == exp_rdy, "R5/R7 ready", 32'(in_ready_o), 32'(exp_rdy));
      if (in_ready_o) begin
        last_long = model_long(a, b);
        if (last_long) model_long_cnt++;
        q_prod.push_back(32'(a) * 32'(b));
        q_cap.push_back(cyc + 1);
        q_long.push_back(last_long);
        prev_acc_cyc = cyc + 1;
        n_acc++;
        done = 1'b1;
      end else begin
        @(negedge clk_i);
      end
    end
    @(posedge clk_i);
    #1 in_valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && out_valid_o) begin
        n_out++;
        if (q_prod.size() == 0) begin
          chk(1'b0, "R6 unexpected strobe", prod_o, 32'h0);
        end else begin
          logic [31:0] ep;
          int          ec;
          bit          el;
          ep = q_prod.pop_front();
          ec = q_cap.pop_front();
          el = q_long.pop_front();
          chk(prod_o == ep, "R2 product", prod_o, ep);
          if (el) chk(cyc - ec == 2, "R4 long latency", 32'(cyc - ec), 32'd2);
          else    chk(cyc - ec == 1, "R3 short latency", 32'(cyc - ec), 32'd1);
          if (cyc - ec == 2) seen_long_cnt++;
          last_prod = ep;
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 valid in reset", 32'(out_valid_o), 32'd0);
    chk(in_ready_o == 1'b1, "R1 ready in reset", 32'(in_ready_o), 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(prod_o == 32'h0, "R1 product after reset", prod_o, 32'h0);
    chk(out_valid_o == 1'b0, "R1 valid after reset", 32'(out_valid_o), 32'd0);

    issue(16'h0000, 16'h0000);
    issue(16'hffff, 16'hffff);
    issue(16'h0001, 16'hffff);
    issue(16'hffff, 16'h0001);
    issue(16'h8000, 16'h8000);
    issue(16'h1234, 16'h0000);

    void'($urandom(7));
    for (int i = 0; i < 1500; i++) begin
      issue(16'($urandom), 16'($urandom));
      if (i % 97 == 0) repeat (2) @(negedge clk_i);
    end

    repeat (6) @(negedge clk_i);
    // R8: idle period leaves the product untouched
    chk(prod_o == last_prod, "R8 product held while idle", prod_o, last_prod);
    chk(out_valid_o == 1'b0, "R8 no strobe while idle", 32'(out_valid_o), 32'd0);
    chk(n_out == n_acc, "R6 one strobe per operation", 32'(n_out), 32'(n_acc));
    chk(q_prod.size() == 0, "R6 nothing left pending", 32'(q_prod.size()), 32'd0);
    chk(seen_long_cnt == model_long_cnt, "R4 stretched count", 32'(seen_long_cnt),
        32'(model_long_cnt));
    chk(model_long_cnt > 0, "R4 long case exercised", 32'(model_long_cnt), 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule